// File: doc/BRIEF.md
# Coprocessor Reset and Interrupt Control

This block is a single 16-bit control word through which a host processor steers a secondary processor. The lower byte holds two line controls: one bit that keeps the secondary processor in reset unless it is set, and one bit that raises a halt, or bus request, toward it. The upper byte holds an interrupt request bit and an enable bit for it. When both are set, the block raises a level-2 interrupt request toward the secondary processor.

The host writes the word through a port with one enable per byte lane and can read the stored value back at any time. When the secondary processor acknowledges an interrupt at level 2, the block clears the pending request bit itself, so the request line falls without any action by the host. During every acknowledge cycle the block also returns the autovector number for the level being acknowledged. That number is (0x60 + 4·level)/4, which is 0x18 plus the level.

After a system reset the word is zero. The secondary processor therefore starts held in reset, with no halt and no interrupt raised.

Top module: `coproc_ctl`

## Requirements
- R1: After system reset the stored word reads 0x0000, `sub_reset` is 1, and `sub_halt` and `sub_irq` are 0.
- R2: A write with `host_be[0]`=1 stores bit 0. From the next cycle `sub_reset` is the inverse of that bit: writing 1 releases the secondary reset and writing 0 asserts it.
- R3: A write with `host_be[0]`=1 stores bit 1. From the next cycle `sub_halt` equals that bit: 1 asserts the halt/bus request and 0 releases it.
- R4: A write with `host_be[0]`=0 leaves bits 7:0, `sub_reset` and `sub_halt` unchanged.
- R5: A write with `host_be[1]`=0 leaves bits 15:8 unchanged.
- R6: Writing bit 8 (the request) as 1 with `host_be[1]`=1 while bit 15 is written as 1 drives `sub_irq` high from the next cycle.
- R7: While bit 15 (the enable) is 0, `sub_irq` is 0 and a pending bit 8 still reads back as 1.
- R8: An acknowledge (`ack_valid`=1) with `ack_level`=2 clears bit 8, and `sub_irq` is 0 from the next cycle. An acknowledge at any other level leaves bit 8 unchanged.
- R9: If a level-2 acknowledge and a host write of bit 8 as 1 with `host_be[1]`=1 fall in the same cycle, the write wins and bit 8 stays 1.
- R10: While `ack_valid`=1, `ack_vector` equals 0x18 + `ack_level`. Otherwise it is 0.
- R11: `host_rdata` always shows the stored word, one cycle after the write or the clear that changed it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| host_wr | input | 1 | Host write strobe |
| host_be | input | 2 | Byte-lane enables; bit 0 is bits 7:0, bit 1 is bits 15:8 |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Stored control word |
| sub_reset | output | 1 | Reset toward the secondary processor, active high |
| sub_halt | output | 1 | Halt / bus request toward the secondary processor |
| sub_irq | output | 1 | Level-2 interrupt request |
| ack_valid | input | 1 | Secondary processor acknowledge cycle |
| ack_level | input | 3 | Level being acknowledged |
| ack_vector | output | 8 | Autovector number returned during the acknowledge |

## Verification
The bench targets the reset-bit polarity. A design that followed the bit directly would let the secondary processor run straight out of system reset, or hold it in reset after the host released it. It writes one byte lane with the other lane disabled, which catches a design that ignores the byte enables and corrupts the halt control or the interrupt enable. It acknowledges at a level other than 2, where a careless design would drop the request, and it holds bit 8 pending with the enable cleared, where a design that clears or exposes the request would be caught. Finally, it places a new request in the same cycle as a level-2 acknowledge, where the wrong priority loses the new interrupt, and it checks that the vector number is 0x18 plus the level.

// File: rtl/coproc_ctl_pkg.sv
// Package: shared constants for the coprocessor control word.
// Assumes a word of whole byte lanes; bit positions are fixed by behaviour.
package coproc_ctl_pkg;
    localparam int CTL_W    = 16;
    localparam int LANE_W   = 8;
    localparam int RST_BIT  = 0;   // 1 releases secondary reset
    localparam int HALT_BIT = 1;   // 1 raises halt / bus request
    localparam int IRQ_BIT  = 8;   // pending interrupt request
    localparam int MASK_BIT = 15;  // interrupt enable
endpackage

// File: rtl/coproc_ctl_regs.sv
// Module: byte-lane control storage with hardware clear of the request bit.
// Assumes CTL_W is a multiple of LANE_W; a host write to a lane wins over the clear.
module coproc_ctl_regs
    import coproc_ctl_pkg::*;
#(
    parameter int W      = CTL_W,
    parameter int LW     = LANE_W,
    parameter int LVL_W  = 3,
    parameter int IRQ_LV = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr,
    input  logic [W/LW-1:0]     be,
    input  logic [W-1:0]        wdata,
    input  logic                ack_valid,
    input  logic [LVL_W-1:0]    ack_level,
    output logic [W-1:0]        word
);
    localparam int NLANES = W / LW;

    logic         ack_hit;
    logic [W-1:0] clr_mask;

    // Decode an acknowledge of the block's own level into a clear mask.
    always_comb begin
        ack_hit  = ack_valid && (ack_level == LVL_W'(IRQ_LV));
        clr_mask = '0;
        clr_mask[IRQ_BIT] = ack_hit;
    end

    for (genvar i = 0; i < NLANES; i++) begin : g_lane
        // One lane: reset to zero, load on enabled write, else apply clear.
        always_ff @(posedge clk) begin
            if (!rst_n)
                word[i*LW +: LW] <= '0;
            else if (wr && be[i])
                word[i*LW +: LW] <= wdata[i*LW +: LW];
            else
                word[i*LW +: LW] <= word[i*LW +: LW] & ~clr_mask[i*LW +: LW];
        end
    end
endmodule

// File: rtl/coproc_ctl_lines.sv
// Module: maps stored control bits onto the secondary processor's lines.
// Assumes the inputs come straight from registers, so outputs are glitch-free.
module coproc_ctl_lines (
    input  logic rst_ctl,
    input  logic halt_ctl,
    input  logic irq_pend,
    input  logic irq_en,
    output logic sub_reset,
    output logic sub_halt,
    output logic sub_irq
);
    // Inverted reset sense; the request is gated by the enable bit.
    always_comb begin
        sub_reset = !rst_ctl;
        sub_halt  = halt_ctl;
        sub_irq   = irq_pend && irq_en;
    end
endmodule

// File: rtl/coproc_ctl_vec.sv
// Module: autovector number for an acknowledge cycle.
// Assumes VEC_BASE is a multiple of VEC_STEP; result is 0 outside acknowledges.
module coproc_ctl_vec #(
    parameter int LVL_W    = 3,
    parameter int VEC_W    = 8,
    parameter int VEC_BASE = 96,
    parameter int VEC_STEP = 4
) (
    input  logic             ack_valid,
    input  logic [LVL_W-1:0] ack_level,
    output logic [VEC_W-1:0] ack_vector
);
    // Compute (base + level*step)/step and present it only during acknowledge.
    always_comb begin
        if (ack_valid)
            ack_vector = VEC_W'((VEC_BASE + int'(ack_level) * VEC_STEP) / VEC_STEP);
        else
            ack_vector = '0;
    end
endmodule

// File: rtl/coproc_ctl.sv
// Module: top of the coprocessor reset / halt / interrupt control word.
// Assumes a single host writer and a single acknowledging secondary processor.
module coproc_ctl
    import coproc_ctl_pkg::*;
#(
    parameter int IRQ_LEVEL = 2,
    parameter int LVL_W     = 3,
    parameter int VEC_W     = 8,
    parameter int VEC_BASE  = 96,
    parameter int VEC_STEP  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [1:0]        host_be,
    input  logic [15:0]       host_wdata,
    output logic [15:0]       host_rdata,
    output logic              sub_reset,
    output logic              sub_halt,
    output logic              sub_irq,
    input  logic              ack_valid,
    input  logic [LVL_W-1:0]  ack_level,
    output logic [VEC_W-1:0]  ack_vector
);
    logic [CTL_W-1:0] word;

    coproc_ctl_regs #(
        .W(CTL_W), .LW(LANE_W), .LVL_W(LVL_W), .IRQ_LV(IRQ_LEVEL)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(host_wr), .be(host_be),
        .wdata(host_wdata), .ack_valid(ack_valid), .ack_level(ack_level),
        .word(word)
    );

    coproc_ctl_lines u_lines (
        .rst_ctl(word[RST_BIT]), .halt_ctl(word[HALT_BIT]),
        .irq_pend(word[IRQ_BIT]), .irq_en(word[MASK_BIT]),
        .sub_reset(sub_reset), .sub_halt(sub_halt), .sub_irq(sub_irq)
    );

    coproc_ctl_vec #(
        .LVL_W(LVL_W), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
    ) u_vec (
        .ack_valid(ack_valid), .ack_level(ack_level), .ack_vector(ack_vector)
    );

    // Read path exposes the stored word directly.
    always_comb host_rdata = word;
endmodule

// File: rtl/coproc_ctl_chk.sv
// Module: assertion checker bound to coproc_ctl.
// Assumes default field positions; only observes ports.
module coproc_ctl_chk #(
    parameter int IRQ_LEVEL = 2,
    parameter int LVL_W     = 3,
    parameter int VEC_W     = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             host_wr,
    input logic [1:0]       host_be,
    input logic [15:0]      host_wdata,
    input logic [15:0]      host_rdata,
    input logic             sub_reset,
    input logic             sub_halt,
    input logic             sub_irq,
    input logic             ack_valid,
    input logic [LVL_W-1:0] ack_level,
    input logic [VEC_W-1:0] ack_vector
);
    // R2
    reset_sense_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_be[0]) |=> (sub_reset == !$past(host_wdata[0])));
    // R3
    halt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_be[0]) |=> (sub_halt == $past(host_wdata[1])));
    // R4
    low_lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr && host_be[0]) |=> ($stable(host_rdata[7:0]) && $stable(sub_reset) && $stable(sub_halt)));
    // R7
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rdata[15] |-> !sub_irq);
    // R8
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_level == LVL_W'(IRQ_LEVEL) && !(host_wr && host_be[1])) |=> (!sub_irq && !host_rdata[8]));
    // R9
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_level == LVL_W'(IRQ_LEVEL) && host_wr && host_be[1] && host_wdata[8]) |=> host_rdata[8]);
    // R10
    vector_num_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> (ack_vector == VEC_W'(24 + int'(ack_level))));
endmodule

bind coproc_ctl coproc_ctl_chk #(
    .IRQ_LEVEL(IRQ_LEVEL), .LVL_W(LVL_W), .VEC_W(VEC_W)
) u_chk (.*);

// File: tb/coproc_ctl_tb.sv
// Scoreboard bench: the driver pushes expectations, the monitor compares at negedge.
module coproc_ctl_tb;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        host_wr = 0;
    logic [1:0]  host_be = 0;
    logic [15:0] host_wdata = 0;
    logic [15:0] host_rdata;
    logic        sub_reset, sub_halt, sub_irq;
    logic        ack_valid = 0;
    logic [2:0]  ack_level = 0;
    logic [7:0]  ack_vector;

    typedef struct {
        int          due;
        int          sig;
        logic [15:0] exp;
        string       req;
    } exp_t;

    exp_t        q[$];
    int          cyc = 0;
    int          checks = 0;
    int          fails = 0;
    bit          done = 0;
    logic [15:0] m = 16'h0;

    coproc_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_be(host_be),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .sub_reset(sub_reset), .sub_halt(sub_halt), .sub_irq(sub_irq),
        .ack_valid(ack_valid), .ack_level(ack_level), .ack_vector(ack_vector)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [15:0] actual(int sig);
        case (sig)
            0: return host_rdata;
            1: return {15'h0, sub_reset};
            2: return {15'h0, sub_halt};
            3: return {15'h0, sub_irq};
            default: return {8'h0, ack_vector};
        endcase
    endfunction

    // Monitor: pop expectations that are due and compare.
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            exp_t e;
            logic [15:0] a;
            e = q.pop_front();
            a = actual(e.sig);
            checks++;
            if (a !== e.exp) begin
                fails++;
                $display("FAIL %s sig%0d actual=%h expected=%h", e.req, e.sig, a, e.exp);
            end
        end
    end

    task automatic push_state(int due, string req);
        q.push_back('{due, 0, m, req});
        q.push_back('{due, 1, {15'h0, !m[0]}, req});
        q.push_back('{due, 2, {15'h0, m[1]}, req});
        q.push_back('{due, 3, {15'h0, m[8] & m[15]}, req});
    endtask

    // Driver: one cycle of stimulus, model update, expectations.
    task automatic op(string req, bit wr, logic [1:0] be, logic [15:0] wd,
                      bit av, logic [2:0] al);
        logic [15:0] n;
        host_wr = wr; host_be = be; host_wdata = wd;
        ack_valid = av; ack_level = al;
        q.push_back('{cyc, 4, av ? 16'(8'h18 + al) : 16'h0, req});
        n = m;
        if (av && al == 3'd2) n[8] = 1'b0;
        if (wr && be[0]) n[7:0] = wd[7:0];
        if (wr && be[1]) n[15:8] = wd[15:8];
        m = n;
        push_state(cyc + 1, req);
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        push_state(cyc, "R1");
        @(posedge clk); #1;
        rst_n = 1;
        op("R2", 1, 2'b01, 16'h0001, 0, 0);
        op("R3", 1, 2'b01, 16'h0003, 0, 0);
        op("R2", 1, 2'b01, 16'h0002, 0, 0);
        op("R4", 1, 2'b10, 16'h00FF, 0, 0);
        op("R4", 1, 2'b00, 16'hFFFD, 0, 0);
        op("R6", 1, 2'b10, 16'h8100, 0, 0);
        op("R5", 1, 2'b01, 16'hFF01, 0, 0);
        op("R8", 0, 2'b00, 16'h0000, 1, 3'd3);
        op("R10", 0, 2'b00, 16'h0000, 1, 3'd5);
        op("R8", 0, 2'b00, 16'h0000, 1, 3'd2);
        op("R7", 1, 2'b10, 16'h0100, 0, 0);
        op("R7", 0, 2'b00, 16'h0000, 1, 3'd1);
        op("R6", 1, 2'b10, 16'h8100, 0, 0);
        op("R9", 1, 2'b10, 16'h8100, 1, 3'd2);
        op("R11", 1, 2'b11, 16'h8103, 0, 0);
        op("R11", 0, 2'b00, 16'h0000, 0, 0);
        repeat (2) @(posedge clk);
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        #(20000 * 10);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule